// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

The block is a word-addressed general-purpose I/O controller for up to 32 pins. Software reaches it through a plain register bus: a word address, a write strobe, write data, and read data that is combinational on the address. Each pin has a direction bit. Output levels change only through two write strobes: one raises the selected bits and one lowers them. The synchronized input levels can be read back.

Every pin input passes through a two-flop synchronizer. It then passes through an optional per-pin debounce filter before it reaches the readback path and the interrupt detector. Each detector can be set to level or edge sensing. In edge mode it can watch one edge or both edges, and a polarity bit selects the active level or edge. Edge events stay latched until software clears them with a write-one-to-clear strobe. Raw status and masked status can both be read. A single interrupt line is the OR of the masked status bits.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_o` and `pin_oe_o` are 0, and `irq_o` is 0.
- R2: Word 0 holds the direction bits, where 1 means the pin is an output. It reads back as written and drives `pin_oe_o`.
- R3: Writing word 2 raises every output bit written as 1 and leaves bits written as 0 unchanged. Word 4 reads the output state, which drives `pin_o`. Writes to word 4 are ignored.
- R4: Writing word 3 lowers every output bit written as 1 and leaves bits written as 0 unchanged.
- R5: Word 5 returns the pin inputs after a two-flop synchronizer. A change shows in the read data after two clock edges when debounce is off.
- R6: When a pin's bit in word 14 is 1, a new input level is accepted only after it has differed from the accepted level for 4 consecutive clocks. Shorter pulses are dropped.
- R7: A raw status bit (word 10) can be 1 only while that pin's enable bit in word 6 is 1 and its direction bit is 0.
- R8: In edge mode (word 7 bit = 0), a bit of 1 in word 8 latches on either edge. Otherwise word 9 selects the edge: 1 for rising, 0 for falling. A matching edge sets the raw bit 3 clock edges after the pin changes.
- R9: In level mode (word 7 bit = 1), the raw bit follows the synchronized input, active high when the word 9 bit is 1 and active low when it is 0. The clear strobe does not affect it.
- R10: Writing 1 to a bit of word 13 clears that latched edge bit. Bits written as 0 keep their state.
- R11: A word 11 bit of 1 masks the pin. Word 12 reads raw AND NOT mask, and `irq_o` is the OR of word 12.
- R12: Words 1 and 15 are read/write storage with no effect on pins. Words 2, 3 and 13 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_i | input | N_PINS | Pin input levels |
| pin_o | output | N_PINS | Pin output levels |
| pin_oe_o | output | N_PINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle:
- the set and clear strobes take effect on the next cycle;
- a latched edge bit holds until it is cleared or disabled;
- an edge bit is set only after an accepted input transition;
- a debounced level changes only to the value the synchronizer held;
- the interrupt line never rises without an enabled input pin.

Only the bench scenarios can show the rest:
- the exact latency of synchronization, debounce and edge latching;
- the rejection of a 3-clock glitch;
- the per-mode edge selection;
- level-mode immunity to the clear strobe;
- the effect of the mask.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    REG_DIR    = 4'd0,
    REG_CTRL   = 4'd1,
    REG_SET    = 4'd2,
    REG_CLR    = 4'd3,
    REG_OUT    = 4'd4,
    REG_IN     = 4'd5,
    REG_IEN    = 4'd6,
    REG_SENSE  = 4'd7,
    REG_BOTH   = 4'd8,
    REG_POL    = 4'd9,
    REG_RAW    = 4'd10,
    REG_MASK   = 4'd11,
    REG_MIS    = 4'd12,
    REG_ICLR   = 4'd13,
    REG_DEBEN  = 4'd14,
    REG_DEBCFG = 4'd15
  } reg_idx_e;

  localparam int unsigned BUS_W = 32;
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned N_PINS    = 32,
  parameter int unsigned DB_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] deb_en_i,
  output logic [N_PINS-1:0] in_o
);
  localparam int unsigned CNT_W = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  logic [N_PINS-1:0] s1_q, s2_q, filt_q;
  logic [CNT_W-1:0]  cnt_q [N_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      filt_q <= '0;
      for (int i = 0; i < int'(N_PINS); i++) cnt_q[i] <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      for (int i = 0; i < int'(N_PINS); i++) begin
        if (!deb_en_i[i]) begin
          filt_q[i] <= s2_q[i];
          cnt_q[i]  <= '0;
        end else if (s2_q[i] == filt_q[i]) begin
          cnt_q[i] <= '0;
        end else if (cnt_q[i] == CNT_LAST) begin
          filt_q[i] <= s2_q[i];
          cnt_q[i]  <= '0;
        end else begin
          cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  assign in_o = (deb_en_i & filt_q) | (~deb_en_i & s2_q);

  // R6
  deb_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((in_o ^ $past(in_o)) & deb_en_i & $past(deb_en_i) & (in_o ^ $past(s2_q))) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] in_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_PINS-1:0] sense_i,
  input  logic [N_PINS-1:0] both_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] raw_o
);
  logic [N_PINS-1:0] prev_q, edge_q, hit, lvl;

  for (genvar g = 0; g < int'(N_PINS); g++) begin : g_pin
    logic rise, fall;
    assign rise     = in_i[g] & ~prev_q[g];
    assign fall     = ~in_i[g] & prev_q[g];
    assign hit[g]   = ~sense_i[g] & (both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall));
    assign lvl[g]   = pol_i[g] ? in_i[g] : ~in_i[g];
    assign raw_o[g] = en_i[g] & (sense_i[g] ? lvl[g] : edge_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= in_i;
      edge_q <= en_i & ((edge_q & ~clr_i) | hit);
    end
  end

  // R10
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_q & $past(edge_q & en_i & ~clr_i)) == $past(edge_q & en_i & ~clr_i)));

  // R8
  edge_needs_transition_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_q & ~$past(edge_q) & ~($past(in_i) ^ $past(prev_q))) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_PINS-1:0] in_i,
  input  logic [N_PINS-1:0] raw_i,
  input  logic [N_PINS-1:0] mis_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0] both_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] mask_o,
  output logic [N_PINS-1:0] deb_en_o,
  output logic [N_PINS-1:0] iclr_o
);
  reg_idx_e          idx;
  logic [N_PINS-1:0] wbits;
  logic [BUS_W-1:0]  ctrl_q, dbcfg_q;

  assign idx   = reg_idx_e'(addr_i);
  assign wbits = wdata_i[N_PINS-1:0];

  function automatic logic [BUS_W-1:0] ext(input logic [N_PINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[N_PINS-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o    <= '0;
      out_o    <= '0;
      ien_o    <= '0;
      sense_o  <= '0;
      both_o   <= '0;
      pol_o    <= '0;
      mask_o   <= '0;
      deb_en_o <= '0;
      ctrl_q   <= '0;
      dbcfg_q  <= '0;
    end else if (we_i) begin
      case (idx)
        REG_DIR:    dir_o    <= wbits;
        REG_CTRL:   ctrl_q   <= wdata_i;
        REG_SET:    out_o    <= out_o | wbits;
        REG_CLR:    out_o    <= out_o & ~wbits;
        REG_IEN:    ien_o    <= wbits;
        REG_SENSE:  sense_o  <= wbits;
        REG_BOTH:   both_o   <= wbits;
        REG_POL:    pol_o    <= wbits;
        REG_MASK:   mask_o   <= wbits;
        REG_DEBEN:  deb_en_o <= wbits;
        REG_DEBCFG: dbcfg_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign iclr_o = (we_i && idx == REG_ICLR) ? wbits : '0;

  always_comb begin
    case (idx)
      REG_DIR:    rdata_o = ext(dir_o);
      REG_CTRL:   rdata_o = ctrl_q;
      REG_OUT:    rdata_o = ext(out_o);
      REG_IN:     rdata_o = ext(in_i);
      REG_IEN:    rdata_o = ext(ien_o);
      REG_SENSE:  rdata_o = ext(sense_o);
      REG_BOTH:   rdata_o = ext(both_o);
      REG_POL:    rdata_o = ext(pol_o);
      REG_RAW:    rdata_o = ext(raw_i);
      REG_MASK:   rdata_o = ext(mask_o);
      REG_MIS:    rdata_o = ext(mis_i);
      REG_DEBEN:  rdata_o = ext(deb_en_o);
      REG_DEBCFG: rdata_o = dbcfg_q;
      default:    rdata_o = '0;
    endcase
  end

  // R3
  set_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == REG_SET) |=> ((out_o & $past(wbits)) == $past(wbits)));

  // R4
  clr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == REG_CLR) |=> ((out_o & $past(wbits)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS    = 32,
  parameter int unsigned DB_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] in_v, raw, mis, dir_q, out_q, ien_q, sense_q, both_q, pol_q, mask_q, deb_en_q, iclr;
  logic [N_PINS-1:0] en_eff;

  gpio_regfile #(.N_PINS(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .in_i(in_v), .raw_i(raw), .mis_i(mis),
    .dir_o(dir_q), .out_o(out_q), .ien_o(ien_q), .sense_o(sense_q),
    .both_o(both_q), .pol_o(pol_q), .mask_o(mask_q), .deb_en_o(deb_en_q),
    .iclr_o(iclr)
  );

  gpio_in_filter #(.N_PINS(N_PINS), .DB_CYCLES(DB_CYCLES)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .deb_en_i(deb_en_q), .in_o(in_v)
  );

  // detection only on pins configured as inputs
  assign en_eff = ien_q & ~dir_q;

  gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_v), .en_i(en_eff),
    .sense_i(sense_q), .both_i(both_q), .pol_i(pol_q), .clr_i(iclr),
    .raw_o(raw)
  );

  assign mis      = raw & ~mask_q;
  assign irq_o    = |mis;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ien_q & ~dir_q) != '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int N = 32;
  localparam logic [3:0] A_DIR = 4'd0, A_CTRL = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
    A_OUT = 4'd4, A_IN = 4'd5, A_IEN = 4'd6, A_SENSE = 4'd7, A_BOTH = 4'd8,
    A_POL = 4'd9, A_RAW = 4'd10, A_MASK = 4'd11, A_MIS = 4'd12, A_ICLR = 4'd13,
    A_DEBEN = 4'd14, A_DEBCFG = 4'd15;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // {write addr, write data, read addr, expected, requirement number}
  localparam logic [75:0] TBL [0:11] = '{
    {A_DIR,    32'h0000_00F0, A_DIR,    32'h0000_00F0, 4'd2},  // R2
    {A_SET,    32'h0000_0033, A_OUT,    32'h0000_0033, 4'd3},  // R3
    {A_SET,    32'h0000_0100, A_OUT,    32'h0000_0133, 4'd3},  // R3
    {A_CLR,    32'h0000_0011, A_OUT,    32'h0000_0122, 4'd4},  // R4
    {A_CLR,    32'h0000_0000, A_OUT,    32'h0000_0122, 4'd4},  // R4
    {A_OUT,    32'h0000_FFFF, A_OUT,    32'h0000_0122, 4'd3},  // R3 write ignored
    {A_CTRL,   32'h0000_A5A5, A_CTRL,   32'h0000_A5A5, 4'd12}, // R12
    {A_DEBCFG, 32'h0000_1234, A_DEBCFG, 32'h0000_1234, 4'd12}, // R12
    {A_SET,    32'h0000_00FF, A_SET,    32'h0000_0000, 4'd12}, // R12 strobe reads 0
    {A_MASK,   32'h0000_F0F0, A_MASK,   32'h0000_F0F0, 4'd11}, // R11
    {A_DIR,    32'h0000_0000, A_DIR,    32'h0000_0000, 4'd2},  // R2
    {A_MASK,   32'h0000_0000, A_MASK,   32'h0000_0000, 4'd11}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 pin_o", 32'(pin_out), 32'h0);
    chk("R1 pin_oe_o", 32'(pin_oe), 32'h0);
    chk("R1 irq_o", 32'(irq), 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][75:72], TBL[i][71:40]);
      rd(TBL[i][39:36], v);
      chk($sformatf("R%0d table %0d", TBL[i][3:0], i), v, TBL[i][35:4]);
    end
    chk("R3 pin_o", 32'(pin_out), 32'h0000_01FF);
    wr(A_DIR, 32'h3);
    chk("R2 pin_oe_o", 32'(pin_oe), 32'h3);
    wr(A_DIR, 32'h0);

    // R5 synchronizer latency
    pin_in = 32'h5;
    step(1);
    rd(A_IN, v); chk("R5 after one edge", v, 32'h0);
    step(1);
    rd(A_IN, v); chk("R5 after two edges", v, 32'h5);
    pin_in = '0;
    step(3);

    // R8 rising
    wr(A_POL, 32'h1); wr(A_SENSE, 32'h0); wr(A_BOTH, 32'h0); wr(A_IEN, 32'h1);
    pin_in[0] = 1'b1; step(2);
    rd(A_RAW, v); chk("R8 not yet latched", v, 32'h0);
    step(1);
    rd(A_RAW, v); chk("R8 rising latched", v, 32'h1);
    chk("R11 irq on raw", 32'(irq), 32'h1);
    wr(A_ICLR, 32'h0);
    rd(A_RAW, v); chk("R10 clear zero kept", v, 32'h1);
    wr(A_ICLR, 32'h1);
    rd(A_RAW, v); chk("R10 clear one", v, 32'h0);
    pin_in[0] = 1'b0; step(3);
    rd(A_RAW, v); chk("R8 falling ignored in rising mode", v, 32'h0);

    // R8 falling
    wr(A_POL, 32'h0);
    pin_in[0] = 1'b1; step(3);
    rd(A_RAW, v); chk("R8 rising ignored in falling mode", v, 32'h0);
    pin_in[0] = 1'b0; step(3);
    rd(A_RAW, v); chk("R8 falling latched", v, 32'h1);
    wr(A_ICLR, 32'h1);

    // R8 both edges
    wr(A_BOTH, 32'h1);
    pin_in[0] = 1'b1; step(3);
    rd(A_RAW, v); chk("R8 both rising", v, 32'h1);
    wr(A_ICLR, 32'h1);
    pin_in[0] = 1'b0; step(3);
    rd(A_RAW, v); chk("R8 both falling", v, 32'h1);

    // R11 mask
    wr(A_MASK, 32'h1);
    rd(A_MIS, v); chk("R11 masked status", v, 32'h0);
    chk("R11 irq masked", 32'(irq), 32'h0);
    rd(A_RAW, v); chk("R11 raw unaffected by mask", v, 32'h1);
    wr(A_MASK, 32'h0);
    rd(A_MIS, v); chk("R11 unmasked status", v, 32'h1);
    chk("R11 irq unmasked", 32'(irq), 32'h1);
    wr(A_ICLR, 32'h1);
    chk("R11 irq after clear", 32'(irq), 32'h0);

    // R7 enable and direction gating
    wr(A_IEN, 32'h0);
    pin_in[0] = 1'b1; step(3);
    rd(A_RAW, v); chk("R7 disabled pin", v, 32'h0);
    wr(A_DIR, 32'h1); wr(A_IEN, 32'h1);
    pin_in[0] = 1'b0; step(3);
    rd(A_RAW, v); chk("R7 output pin", v, 32'h0);
    chk("R7 irq output pin", 32'(irq), 32'h0);
    wr(A_DIR, 32'h0);
    rd(A_RAW, v); chk("R7 no stale event", v, 32'h0);
    wr(A_IEN, 32'h0); wr(A_BOTH, 32'h0);

    // R9 level mode on pin 1
    wr(A_SENSE, 32'h2); wr(A_POL, 32'h2); wr(A_IEN, 32'h2);
    rd(A_RAW, v); chk("R9 high level idle", v, 32'h0);
    pin_in[1] = 1'b1; step(2);
    rd(A_RAW, v); chk("R9 high level active", v, 32'h2);
    wr(A_ICLR, 32'h2);
    rd(A_RAW, v); chk("R9 clear ignored", v, 32'h2);
    pin_in[1] = 1'b0; step(2);
    rd(A_RAW, v); chk("R9 level released", v, 32'h0);
    wr(A_POL, 32'h0);
    rd(A_RAW, v); chk("R9 active low", v, 32'h2);
    wr(A_IEN, 32'h0); wr(A_SENSE, 32'h0);

    // R6 debounce on pin 3
    wr(A_DEBEN, 32'h8);
    pin_in[3] = 1'b1; step(3);
    pin_in[3] = 1'b0; step(8);
    rd(A_IN, v); chk("R6 short pulse dropped", v & 32'h8, 32'h0);
    pin_in[3] = 1'b1; step(5);
    rd(A_IN, v); chk("R6 not yet stable", v & 32'h8, 32'h0);
    step(1);
    rd(A_IN, v); chk("R6 accepted after 4 stable", v & 32'h8, 32'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule